// File: doc/BRIEF.md
# SIMD Lane Copy Execution Unit

This unit decodes and carries out the vector copy group of a 64-bit SIMD extension. It receives one 32-bit instruction word with a strobe, the 128-bit source vector, the previous 128-bit value of the destination vector and a 64-bit general-purpose operand. It returns a 128-bit vector result or a 64-bit general-register result, each with its own write enable, plus a flag that marks an undefined encoding.

Six operations are supported:

- broadcasting a vector lane into every lane;
- broadcasting a general operand into every lane;
- inserting a vector lane into one destination lane;
- inserting a general operand into one destination lane;
- moving a lane to a general register with sign extension;
- moving a lane to a general register with zero extension.

Element size and lane index share one 5-bit immediate. The lowest set bit of that immediate gives the size, and the bits above it give the index. The register file around the unit reads the operands and commits whichever result is enabled, one clock after the strobe.

Top module: `lane_copy_unit`

## Requirements
- R1: Fields are taken from fixed positions: destination register field bits 4:0, source register field bits 9:5, imm4 bits 14:11, imm5 bits 20:16, op bit 29, Q bit 30. All other bits, including both register fields, have no effect on the results. The size code is the count of trailing zeros of imm5, and the element width is 8 << size. When imm5 is 0 or 5'b10000, the encoding is undefined.
- R2: The operation is selected as follows:
  - op=1 with Q=1 inserts from a vector lane, and op=1 with Q=0 is undefined.
  - With op=0, imm4 selects the operation: 0 broadcasts a lane, 1 broadcasts the general operand, 3 inserts the general operand (Q=0 is undefined), 5 is a signed move and 7 is an unsigned move.
  - Any other imm4 value with op=0 is undefined.
- R3: A lane broadcast copies source lane imm5 >> (size+1) into every lane. Q=1 fills 128 bits. Q=0 fills the low 64 bits and zeroes bits 127:64. Size 3 with Q=0 is undefined.
- R4: A general broadcast replicates the low element-width bits of the general operand, with the same Q rules as R3.
- R5: A lane insert copies source lane imm4 >> size into destination lane imm5 >> (size+1). Every other bit of the old destination vector is returned unchanged.
- R6: A general insert writes the low element-width bits of the general operand into destination lane imm5 >> (size+1). Every other bit of the old destination vector is returned unchanged.
- R7: A signed move is legal for sizes 0-1 when Q=0 and for sizes 0-2 when Q=1. It returns the lane sign-extended to 64 bits. When Q=0, bits 63:32 of the result are zero.
- R8: An unsigned move is legal only for size 3 with Q=1, or for sizes 0-2 with Q=0. It returns the lane zero-extended to 64 bits.
- R9: An undefined encoding raises the undefined flag and holds both write enables low.
- R10: Results, enables and the flag appear on the cycle after the strobe. A cycle without the strobe leaves enables and flag low on the next cycle. A synchronous active-high reset clears enables and flag.
- R11: The broadcast and insert operations raise only the vector write enable. The move operations raise only the general write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| vsrc | input | 128 | Source vector |
| vdst_old | input | 128 | Previous destination vector value |
| gsrc | input | 64 | General-purpose source operand |
| vres | output | 128 | Vector result |
| vres_we | output | 1 | Vector result write enable |
| gres | output | 64 | General-register result |
| gres_we | output | 1 | General result write enable |
| undef_o | output | 1 | Undefined encoding flag |

## Verification
The unit has no parameters. Every width is fixed by the instruction format, so the bench builds the single configuration there is. Because of this, the whole decode space is small enough to walk completely: every op, Q, imm5 and imm4 combination of each operation is compared against a lane-by-lane reference model. Random register-field bits and random operands are used throughout, and lanes with the top bit set exercise the sign-extension paths.

// File: rtl/lane_copy_unit.sv
module lane_copy_unit (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [31:0]  insn,
  input  logic [127:0] vsrc,
  input  logic [127:0] vdst_old,
  input  logic [63:0]  gsrc,
  output logic [127:0] vres,
  output logic         vres_we,
  output logic [63:0]  gres,
  output logic         gres_we,
  output logic         undef_o
);

  typedef enum logic [2:0] {K_DUPE, K_DUPG, K_INSE, K_INSG, K_SMOV, K_UMOV, K_BAD} kind_t;

  wire [4:0] imm5 = insn[20:16];
  wire [3:0] imm4 = insn[14:11];
  wire       op   = insn[29];
  wire       q    = insn[30];

  logic [2:0] sz;
  always_comb begin
    casez (imm5)
      5'b????1: sz = 3'd0;
      5'b???10: sz = 3'd1;
      5'b??100: sz = 3'd2;
      5'b?1000: sz = 3'd3;
      default:  sz = 3'd4;
    endcase
  end

  wire [4:0] idx5    = imm5 >> (sz + 3'd1);
  wire [3:0] dst_idx = idx5[3:0];
  wire [3:0] src_idx = imm4 >> sz;

  function automatic logic [63:0] pick(input logic [127:0] v, input logic [2:0] s, input logic [3:0] i);
    case (s)
      3'd0:    pick = {56'b0, v[{i, 3'b0} +: 8]};
      3'd1:    pick = {48'b0, v[{i[2:0], 4'b0} +: 16]};
      3'd2:    pick = {32'b0, v[{i[1:0], 5'b0} +: 32]};
      default: pick = v[{i[0], 6'b0} +: 64];
    endcase
  endfunction

  kind_t kind;
  always_comb begin
    kind = K_BAD;
    if (op) kind = q ? K_INSE : K_BAD;
    else begin
      case (imm4)
        4'd0: kind = K_DUPE;
        4'd1: kind = K_DUPG;
        4'd3: kind = q ? K_INSG : K_BAD;
        4'd5: kind = K_SMOV;
        4'd7: kind = K_UMOV;
        default: kind = K_BAD;
      endcase
    end
  end

  logic legal;
  always_comb begin
    legal = (sz != 3'd4);
    case (kind)
      K_DUPE, K_DUPG: if (sz == 3'd3 && !q) legal = 1'b0;
      K_SMOV:         if (q ? sz > 3'd2 : sz > 3'd1) legal = 1'b0;
      K_UMOV:         if (q ? sz != 3'd3 : sz > 3'd2) legal = 1'b0;
      K_BAD:          legal = 1'b0;
      default:        ;
    endcase
  end

  wire is_vec = (kind == K_DUPE) || (kind == K_DUPG) || (kind == K_INSE) || (kind == K_INSG);
  wire is_gen = (kind == K_SMOV) || (kind == K_UMOV);

  logic [63:0] gmask;
  always_comb begin
    case (sz)
      3'd0:    gmask = {56'b0, gsrc[7:0]};
      3'd1:    gmask = {48'b0, gsrc[15:0]};
      3'd2:    gmask = {32'b0, gsrc[31:0]};
      default: gmask = gsrc;
    endcase
  end

  logic [63:0] elem;
  always_comb begin
    case (kind)
      K_INSE:         elem = pick(vsrc, sz, src_idx);
      K_DUPG, K_INSG: elem = gmask;
      default:        elem = pick(vsrc, sz, dst_idx);
    endcase
  end

  logic [127:0] rep;
  always_comb begin
    case (sz)
      3'd0:    rep = {16{elem[7:0]}};
      3'd1:    rep = {8{elem[15:0]}};
      3'd2:    rep = {4{elem[31:0]}};
      default: rep = {2{elem}};
    endcase
  end

  logic [127:0] ins_v;
  always_comb begin
    for (int b = 0; b < 16; b++) begin
      logic [3:0] lane;
      lane = 4'(b) >> sz;
      ins_v[b*8 +: 8] = (lane == dst_idx) ? rep[b*8 +: 8] : vdst_old[b*8 +: 8];
    end
  end

  wire [127:0] dup_v = q ? rep : {64'b0, rep[63:0]};
  wire [127:0] vnext = (kind == K_INSE || kind == K_INSG) ? ins_v : dup_v;

  logic [63:0] sx;
  always_comb begin
    case (sz)
      3'd0:    sx = {{56{elem[7]}}, elem[7:0]};
      3'd1:    sx = {{48{elem[15]}}, elem[15:0]};
      default: sx = {{32{elem[31]}}, elem[31:0]};
    endcase
  end

  wire [63:0] gnext = (kind == K_UMOV) ? elem : (q ? sx : {32'b0, sx[31:0]});

  always_ff @(posedge clk) begin
    if (rst) begin
      vres_we <= 1'b0;
      gres_we <= 1'b0;
      undef_o <= 1'b0;
    end else begin
      vres_we <= in_valid & legal & is_vec;
      gres_we <= in_valid & legal & is_gen;
      undef_o <= in_valid & ~legal;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      vres <= vnext;
      gres <= gnext;
    end
  end

endmodule

module lane_copy_unit_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [31:0]  insn,
  input logic [127:0] vres,
  input logic         vres_we,
  input logic [63:0]  gres,
  input logic         gres_we,
  input logic         undef_o
);

  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(vres_we && gres_we)); // R11
  AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (rst) undef_o |-> (!vres_we && !gres_we)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!vres_we && !gres_we && !undef_o)); // R10
  AST_STROBE_ANSWERS: assert property (@(posedge clk) disable iff (rst) in_valid |=> $countones({vres_we, gres_we, undef_o}) == 1); // R10
  AST_NARROW_DUP_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !insn[29] && !insn[30] && (insn[14:11] == 4'd0 || insn[14:11] == 4'd1))
      |=> (!vres_we || vres[127:64] == 64'b0)); // R3
  AST_NARROW_SMOV_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !insn[29] && !insn[30] && insn[14:11] == 4'd5)
      |=> (!gres_we || gres[63:32] == 32'b0)); // R7
  AST_OP1_Q0_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[29] && !insn[30]) |=> undef_o); // R2

endmodule

bind lane_copy_unit lane_copy_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
  .vres(vres), .vres_we(vres_we), .gres(gres), .gres_we(gres_we), .undef_o(undef_o)
);

// File: tb/lane_copy_unit_tb.sv
`timescale 1ns/1ps
module lane_copy_unit_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] vsrc = '0;
  logic [127:0] vdst_old = '0;
  logic [63:0]  gsrc = '0;
  logic [127:0] vres;
  logic         vres_we;
  logic [63:0]  gres;
  logic         gres_we;
  logic         undef_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lane_copy_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .vsrc(vsrc), .vdst_old(vdst_old), .gsrc(gsrc),
    .vres(vres), .vres_we(vres_we), .gres(gres), .gres_we(gres_we), .undef_o(undef_o)
  );

  task automatic model(input logic [31:0] ins, input logic [127:0] vs, input logic [127:0] vd,
                       input logic [63:0] g, output bit eb, output bit ev, output bit eg,
                       output logic [127:0] vr, output logic [63:0] gr);
    int sz, esz, nl, di, si;
    bit q, op;
    logic [3:0] i4;
    logic [4:0] i5;
    logic [63:0] m, e;
    q = ins[30]; op = ins[29]; i4 = ins[14:11]; i5 = ins[20:16];
    eb = 0; ev = 0; eg = 0; vr = '0; gr = '0;
    sz = -1;
    for (int k = 0; k < 4; k++) if (sz < 0 && i5[k]) sz = k;
    if (sz < 0) begin eb = 1; return; end
    esz = 8 << sz;
    m = (sz == 3) ? '1 : ((64'd1 << esz) - 64'd1);
    di = int'(i5) >> (sz + 1);
    si = int'(i4) >> sz;
    nl = (q ? 128 : 64) / esz;
    if (op) begin
      if (!q) begin eb = 1; return; end
      e = 64'(vs >> (si * esz)) & m;
      vr = (vd & ~(128'(m) << (di * esz))) | (128'(e) << (di * esz));
      ev = 1;
    end else if (i4 == 0 || i4 == 1) begin
      if (sz == 3 && !q) begin eb = 1; return; end
      e = (i4 == 0) ? (64'(vs >> (di * esz)) & m) : (g & m);
      for (int l = 0; l < nl; l++) vr = vr | (128'(e) << (l * esz));
      ev = 1;
    end else if (i4 == 3) begin
      if (!q) begin eb = 1; return; end
      e = g & m;
      vr = (vd & ~(128'(m) << (di * esz))) | (128'(e) << (di * esz));
      ev = 1;
    end else if (i4 == 5) begin
      if (q ? sz > 2 : sz > 1) begin eb = 1; return; end
      e = 64'(vs >> (di * esz)) & m;
      if (e[esz-1]) e = e | ~m;
      if (!q) e = e & 64'h0000_0000_ffff_ffff;
      gr = e; eg = 1;
    end else if (i4 == 7) begin
      if (q ? sz != 3 : sz > 2) begin eb = 1; return; end
      gr = 64'(vs >> (di * esz)) & m; eg = 1;
    end else eb = 1;
  endtask

  task automatic run_one(input logic [31:0] ins, input string tag);
    bit eb, ev, eg, ok;
    logic [127:0] evr;
    logic [63:0] egr;
    @(negedge clk);
    insn = ins;
    vsrc = {$urandom, $urandom, $urandom, $urandom};
    vdst_old = {$urandom, $urandom, $urandom, $urandom};
    gsrc = {$urandom, $urandom};
    in_valid = 1'b1;
    model(insn, vsrc, vdst_old, gsrc, eb, ev, eg, evr, egr);
    @(negedge clk);
    in_valid = 1'b0;
    ok = (undef_o === eb) && (vres_we === ev) && (gres_we === eg);
    if (ok && ev) ok = (vres === evr);
    if (ok && eg) ok = (gres === egr);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s insn=%h got u=%b vw=%b gw=%b v=%h g=%h exp u=%b vw=%b gw=%b v=%h g=%h",
               tag, ins, undef_o, vres_we, gres_we, vres, gres, eb, ev, eg, evr, egr);
    end
  endtask

  function automatic logic [31:0] mk(bit q, bit op, logic [3:0] i4, logic [4:0] i5);
    logic [31:0] w;
    w = {$urandom};
    w[30] = q; w[29] = op; w[14:11] = i4; w[20:16] = i5;
    return w;
  endfunction

  task automatic check_sig(input bit cond, input string tag, input string what);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s: vw=%b gw=%b u=%b exp all 0", tag, what, vres_we, gres_we, undef_o);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_sig(!vres_we && !gres_we && !undef_o, "R10", "reset state");
  endtask

  task automatic t_dup_lane;
    for (int q = 0; q < 2; q++)
      for (int i5 = 0; i5 < 32; i5++) run_one(mk(q[0], 1'b0, 4'd0, 5'(i5)), "R3 R1");
  endtask

  task automatic t_dup_gen;
    for (int q = 0; q < 2; q++)
      for (int i5 = 0; i5 < 32; i5++) run_one(mk(q[0], 1'b0, 4'd1, 5'(i5)), "R4 R11");
  endtask

  task automatic t_ins_lane;
    for (int q = 0; q < 2; q++)
      for (int i5 = 0; i5 < 32; i5++)
        for (int i4 = 0; i4 < 16; i4++) run_one(mk(q[0], 1'b1, 4'(i4), 5'(i5)), "R5 R2");
  endtask

  task automatic t_ins_gen;
    for (int q = 0; q < 2; q++)
      for (int i5 = 0; i5 < 32; i5++) run_one(mk(q[0], 1'b0, 4'd3, 5'(i5)), "R6");
  endtask

  task automatic t_smov;
    for (int rep = 0; rep < 4; rep++)
      for (int q = 0; q < 2; q++)
        for (int i5 = 0; i5 < 32; i5++) run_one(mk(q[0], 1'b0, 4'd5, 5'(i5)), "R7");
  endtask

  task automatic t_umov;
    for (int q = 0; q < 2; q++)
      for (int i5 = 0; i5 < 32; i5++) run_one(mk(q[0], 1'b0, 4'd7, 5'(i5)), "R8 R11");
  endtask

  task automatic t_bad_imm4;
    for (int q = 0; q < 2; q++)
      for (int i4 = 0; i4 < 16; i4++)
        if (!(i4 inside {0, 1, 3, 5, 7}))
          for (int i5 = 1; i5 < 32; i5 += 3) run_one(mk(q[0], 1'b0, 4'(i4), 5'(i5)), "R9 R2");
  endtask

  task automatic t_idle;
    run_one(mk(1'b1, 1'b0, 4'd0, 5'd1), "R10");
    @(negedge clk);
    check_sig(!vres_we && !gres_we && !undef_o, "R10", "no strobe");
    run_one(mk(1'b0, 1'b0, 4'd2, 5'd1), "R9");
    @(negedge clk);
    check_sig(!undef_o, "R10", "flag after idle");
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    insn = mk(1'b1, 1'b0, 4'd0, 5'd2);
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b0;
    check_sig(!vres_we && !gres_we && !undef_o, "R10", "reset wins over strobe");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_dup_lane();
    t_dup_gen();
    t_ins_lane();
    t_ins_gen();
    t_smov();
    t_umov();
    t_bad_imm4();
    t_idle();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule